// File: doc/BRIEF.md
# Latched Two-Level Interrupt Aggregator

This block gathers one-cycle event pulses from eight groups of eight sources each and turns them into a single active-low interrupt line for a host processor. Every source has a sticky status bit. Each group has an enable byte. Each group also owns one summary bit in a request byte. A summary bit is set only when a new event arrives on an enabled source. It is cleared when the processor reads that group's status byte, whatever the status bits hold at that time. A source that keeps reporting therefore cannot hold the interrupt line low by itself: only a fresh event raises the line again.

The processor reaches the block through a plain register bus with an address, a read strobe, a write strobe, write data and combinational read data. The interrupt service routine works in three steps. It reads the request byte to find the groups that need service. It reads each flagged status byte, which also clears that status byte. It repeats until the request byte reads zero, which is the moment the line is released.

Top module: `intr_aggregator`

## Requirements
- R1: An event pulse on source bit b of group g sets status bit b of group g on the next clock edge, whether or not that source is enabled. The status bit stays set until its status byte is read. The event vector `ev_i` carries group g in bits [8g+7:8g].
- R2: Request bit g is set on the clock edge after a cycle in which an event arrives on a source whose enable bit is 1. An event on a disabled source leaves request bit g unchanged.
- R3: A read of group g's status byte returns the value held before the read. On the following edge it clears that status byte and request bit g.
- R4: A status bit that is already latched never sets a request bit. This holds even if its enable bit is turned on later. Only a new event pulse can set a request bit.
- R5: `irq_n` is low while any request bit is 1 and high when all request bits are 0.
- R6: The request byte is at address 0x003. Request bit 7 belongs to the status byte at 0x004, bit 6 to 0x005, and so on down to bit 0 at 0x00B. The enable bytes follow the same group order at 0x014 to 0x01B.
- R7: Suppose an event arrives in the same cycle as the status read that clears its group. The event bit stays latched in status. If the event is enabled, the request bit is set again.
- R8: Enable bytes are read/write. Writes to the request byte, to status bytes or to unmapped addresses change nothing. Unmapped addresses read as 0x00, and `rdata_o` is 0x00 when no read is strobed.
- R9: While reset is held, and after it is released, all status, enable and request bits are 0 and `irq_n` is high.
- R10: The request byte reads 0x00 exactly when `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_i | input | 64 | One-cycle event pulses; group g in bits [8g+7:8g] |
| addr_i | input | 12 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_i` |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The hardest case to reach from the ports is a clearing status read that lands in the same cycle as a fresh event in the same group. In that cycle the clear and the set compete for both the status byte and the request bit. Directed steps place a pulse exactly on the read cycle, both with the source enabled and with it disabled. A long random phase then mixes sparse events with random reads and writes, so that such collisions also happen often in varied combinations. A behavioural model checks every read and the pin on every cycle.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int GRP_N_D     = 8;
  localparam int GRP_W_D     = 8;
  localparam int ADDR_W_D    = 12;
  localparam int REQ_ADDR_D  = 3;
  localparam int STAT_BASE_D = 4;
  localparam int EN_BASE_D   = 20;
endpackage

// File: rtl/intagg_rst_sync.sv
module intagg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/intagg_group.sv
module intagg_group #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] ev,
  input  logic             rd_stat,
  input  logic             wr_en,
  input  logic [GRP_W-1:0] wdata,
  output logic [GRP_W-1:0] stat,
  output logic [GRP_W-1:0] en,
  output logic             req
);
  logic [GRP_W-1:0] stat_d;
  logic [GRP_W-1:0] en_d;
  logic             req_d;
  logic             new_hit;

  always_comb begin
    new_hit = |(ev & en);
    stat_d  = (rd_stat ? '0 : stat) | ev;
    en_d    = wr_en ? wdata : en;
    if (new_hit)      req_d = 1'b1;
    else if (rd_stat) req_d = 1'b0;
    else              req_d = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
      req  <= 1'b0;
    end else begin
      stat <= stat_d;
      en   <= en_d;
      req  <= req_d;
    end
  end

  a_r1_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((stat & $past(ev)) == $past(ev)));
  a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev & en)) |=> req);
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !(|(ev & en))) |=> !req);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat && !(|(ev & en))) |=> $stable(req));
  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ev == '0) |=> (stat == '0));
endmodule

// File: rtl/intagg_regbus.sv
module intagg_regbus #(
  parameter int GRP_N     = 8,
  parameter int GRP_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int REQ_ADDR  = 3,
  parameter int STAT_BASE = 4,
  parameter int EN_BASE   = 20
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   rd,
  input  logic                   wr,
  input  logic [GRP_N*GRP_W-1:0] stat_all,
  input  logic [GRP_N*GRP_W-1:0] en_all,
  input  logic [GRP_N-1:0]       req_all,
  output logic [GRP_N-1:0]       rd_stat_hit,
  output logic [GRP_N-1:0]       wr_en_hit,
  output logic [GRP_W-1:0]       rdata
);
  logic [GRP_N-1:0] stat_sel;
  logic [GRP_N-1:0] en_sel;
  logic             req_sel;

  assign req_sel = (addr == ADDR_W'(REQ_ADDR));

  for (genvar g = 0; g < GRP_N; g++) begin : g_dec
    localparam int SA = STAT_BASE + GRP_N - 1 - g;
    localparam int EA = EN_BASE + GRP_N - 1 - g;
    assign stat_sel[g]    = (addr == ADDR_W'(SA));
    assign en_sel[g]      = (addr == ADDR_W'(EA));
    assign rd_stat_hit[g] = rd & stat_sel[g];
    assign wr_en_hit[g]   = wr & en_sel[g];
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (req_sel) rdata = GRP_W'(req_all);
      for (int g = 0; g < GRP_N; g++) begin
        if (stat_sel[g]) rdata = stat_all[g*GRP_W +: GRP_W];
        if (en_sel[g])   rdata = en_all[g*GRP_W +: GRP_W];
      end
    end
  end
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
  import intagg_pkg::*;
#(
  parameter int GRP_N     = GRP_N_D,
  parameter int GRP_W     = GRP_W_D,
  parameter int ADDR_W    = ADDR_W_D,
  parameter int REQ_ADDR  = REQ_ADDR_D,
  parameter int STAT_BASE = STAT_BASE_D,
  parameter int EN_BASE   = EN_BASE_D
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GRP_N*GRP_W-1:0] ev_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [GRP_W-1:0]       wdata_i,
  output logic [GRP_W-1:0]       rdata_o,
  output logic                   irq_n
);
  localparam int EV_W = GRP_N * GRP_W;

  logic             rst_s_n;
  logic [EV_W-1:0]  stat_all;
  logic [EV_W-1:0]  en_all;
  logic [GRP_N-1:0] req_all;
  logic [GRP_N-1:0] rd_stat_hit;
  logic [GRP_N-1:0] wr_en_hit;

  intagg_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    intagg_group #(.GRP_W(GRP_W)) u_grp (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .ev     (ev_i[g*GRP_W +: GRP_W]),
      .rd_stat(rd_stat_hit[g]),
      .wr_en  (wr_en_hit[g]),
      .wdata  (wdata_i),
      .stat   (stat_all[g*GRP_W +: GRP_W]),
      .en     (en_all[g*GRP_W +: GRP_W]),
      .req    (req_all[g])
    );
  end

  intagg_regbus #(
    .GRP_N(GRP_N), .GRP_W(GRP_W), .ADDR_W(ADDR_W),
    .REQ_ADDR(REQ_ADDR), .STAT_BASE(STAT_BASE), .EN_BASE(EN_BASE)
  ) u_bus (
    .addr       (addr_i),
    .rd         (rd_i),
    .wr         (wr_i),
    .stat_all   (stat_all),
    .en_all     (en_all),
    .req_all    (req_all),
    .rd_stat_hit(rd_stat_hit),
    .wr_en_hit  (wr_en_hit),
    .rdata      (rdata_o)
  );

  assign irq_n = ~(|req_all);

  a_r10_exit: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_i && addr_i == ADDR_W'(REQ_ADDR)) |-> ((rdata_o == '0) == irq_n));
  a_r9_idle: assert property (@(posedge clk)
    (!rst_s_n) |-> (irq_n && req_all == '0));
  a_r8_nodata: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!rd_i) |-> (rdata_o == '0));
endmodule

// File: tb/sim_intr_aggregator.sv
module sim_intr_aggregator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] ev_i;
  logic [11:0] addr_i;
  logic        rd_i, wr_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic        irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_stat [8];
  logic [7:0] m_en   [8];
  logic [7:0] m_req;

  always #2 clk = ~clk;

  intr_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .addr_i(addr_i), .rd_i(rd_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_n(irq_n)
  );

  function automatic logic [7:0] m_read(input logic [11:0] a);
    if (a == 12'h003) return m_req;
    if (a >= 12'h004 && a <= 12'h00B) return m_stat[11 - a];
    if (a >= 12'h014 && a <= 12'h01B) return m_en[27 - a];
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [11:0] a, input logic r, input logic w,
                     input logic [7:0] d, input logic [63:0] e, input string tag);
    logic [7:0] exp;
    logic [7:0] old_en [8];
    addr_i = a; rd_i = r; wr_i = w; wdata_i = d; ev_i = e;
    #1;
    exp = r ? m_read(a) : 8'h00;
    check(rdata_o === exp, {tag, " R8 rdata"}, rdata_o, exp);
    check(irq_n === (m_req == 8'h00), "R5 R10 irq_n", {7'd0, irq_n}, {7'd0, m_req == 8'h00});
    @(posedge clk);
    for (int g = 0; g < 8; g++) old_en[g] = m_en[g];
    for (int g = 0; g < 8; g++) begin
      bit hit = r && (a == 12'(11 - g));
      if (|(e[g*8 +: 8] & old_en[g])) m_req[g] = 1'b1;
      else if (hit)                   m_req[g] = 1'b0;
      m_stat[g] = (hit ? 8'h00 : m_stat[g]) | e[g*8 +: 8];
      if (w && a == 12'(27 - g)) m_en[g] = d;
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(12'h000, 1'b0, 1'b0, 8'h00, 64'h0, tag);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(a, 1'b1, 1'b0, 8'h00, 64'h0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input string tag);
    cyc(a, 1'b0, 1'b1, d, 64'h0, tag);
  endtask

  function automatic logic [63:0] grp_ev(input int g, input logic [7:0] b);
    logic [63:0] v = 64'h0;
    v[g*8 +: 8] = b;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_i = '0; addr_i = '0; rd_i = 0; wr_i = 0; wdata_i = '0;
    for (int g = 0; g < 8; g++) begin m_stat[g] = 0; m_en[g] = 0; end
    m_req = 0;
    repeat (3) @(negedge clk);
    // R9: pin high while reset is held
    check(irq_n === 1'b1, "R9 irq_n in reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: every register reads zero after reset
    for (int a = 3; a < 32; a++) rd(12'(a), "R9 reset value");

    // R8 / R6: enable readback in group order
    wr(12'h014, 8'hA5, "R8");         // group 7
    wr(12'h01B, 8'h0F, "R8");         // group 0
    wr(12'h017, 8'h80, "R8");         // group 4
    rd(12'h014, "R6 R8 enable g7");
    rd(12'h01B, "R6 R8 enable g0");
    check(m_en[7] == 8'hA5 && m_en[0] == 8'h0F, "R6 model map", m_en[7], 8'hA5);

    // R1/R2: disabled event latches status but no request
    cyc(12'h000, 0, 0, 0, grp_ev(0, 8'h10), "R1 R2 disabled ev");
    idle("R2");
    check(irq_n === 1'b1, "R2 disabled no irq", {7'd0, irq_n}, 8'h01);
    rd(12'h003, "R2 R10 req zero");
    // R4: enabling a latched source later raises nothing
    wr(12'h01B, 8'hFF, "R4 late enable");
    idle("R4");
    check(irq_n === 1'b1, "R4 no irq from old status", {7'd0, irq_n}, 8'h01);
    rd(12'h00B, "R3 R4 read g0 status 0x10");

    // R2/R5/R6: enabled event in group 7 -> bit 7 of request byte
    cyc(12'h000, 0, 0, 0, grp_ev(7, 8'h01), "R2 enabled ev");
    check(irq_n === 1'b0, "R5 irq low", {7'd0, irq_n}, 8'h00);
    rd(12'h003, "R6 R10 req 0x80");
    check(m_req == 8'h80, "R6 model req", m_req, 8'h80);
    // R8: writes to request and status are ignored
    wr(12'h003, 8'h00, "R8 req write");
    wr(12'h004, 8'h00, "R8 stat write");
    wr(12'h030, 8'hFF, "R8 unmapped write");
    rd(12'h003, "R8 req unchanged");
    rd(12'h030, "R8 unmapped read");
    rd(12'h004, "R3 read g7 returns pre-clear");
    rd(12'h004, "R3 g7 cleared");
    check(irq_n === 1'b1, "R3 irq released", {7'd0, irq_n}, 8'h01);

    // R7: event in the cycle of the clearing read, enabled source
    cyc(12'h000, 0, 0, 0, grp_ev(4, 8'h80), "R7 setup");
    cyc(12'h007, 1, 0, 0, grp_ev(4, 8'h80), "R7 collide enabled");
    check(irq_n === 1'b0, "R7 req re-set", {7'd0, irq_n}, 8'h00);
    rd(12'h007, "R7 status kept 0x80");
    check(irq_n === 1'b1, "R7 cleared after", {7'd0, irq_n}, 8'h01);
    // R7: collision on a disabled source keeps status, no request
    cyc(12'h000, 0, 0, 0, grp_ev(3, 8'h02), "R7 setup2");
    cyc(12'h008, 1, 0, 0, grp_ev(3, 8'h04), "R7 collide disabled");
    rd(12'h008, "R7 status 0x04 kept");
    check(irq_n === 1'b1, "R7 no req", {7'd0, irq_n}, 8'h01);

    // random phase: all requirements against the model
    for (int g = 0; g < 8; g++) wr(12'(27 - g), 8'($urandom), "R8 random en");
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] e;
      logic [11:0] a;
      int k;
      e = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
          & {$urandom, $urandom};
      k = $urandom_range(0, 9);
      a = (k == 0) ? 12'h030 : (k < 3) ? 12'h003 : 12'($urandom_range(4, 27));
      cyc(a, ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0), 8'($urandom),
          ($urandom_range(0, 2) == 0) ? e : 64'h0, "R1 R2 R3 R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule